// File: doc/BRIEF.md
# I2C Write Master with Register Front End

This block is an I2C bus master that a host programs through a small byte-wide register file, and it only writes. The host stores a slave address, a sub-address byte, a byte count and up to sixteen payload bytes. It then sets a start bit in the command register. The controller issues a START condition and sends the address byte with the write direction bit. It then sends the sub-address and the queued payload, checking the acknowledge slot after every byte, and finishes with a STOP condition.

Bus timing comes from a prescaler. A functional tick occurs once every `divisor + 1` system clocks, and each SCL bit lasts three ticks. SCL is low for the first and third tick and high for the middle tick. Both bus lines are open-drain: an output-enable pulls the line low, and the SDA level is read back through an input. A missing acknowledge ends the transfer. Status reports it as an address-phase error or a data-phase error, and an optional interrupt flags each completed transfer.

Engine states: `S_IDLE` (bus released), `S_START`, `S_ADDR`, `S_SUBA`, `S_DATA`, `S_STOP`. All state changes happen on a functional tick.
- `S_IDLE -> S_START` when a start is pending.
- `S_START -> S_ADDR` after three ticks.
- After the acknowledge slot, `S_ADDR` moves on to `S_SUBA` if the slave acknowledged and to `S_STOP` if it did not.
- After the acknowledge slot, `S_SUBA` moves on to `S_DATA` on an acknowledge and to `S_STOP` on a missing acknowledge.
- After the acknowledge slot, `S_DATA` stays in `S_DATA` while payload bytes remain. It moves to `S_STOP` after the last byte or on a missing acknowledge.
- `S_STOP -> S_IDLE` after three ticks.

Top module: `i2cw_master`

## Requirements
- R1: After reset, the status register (offset 9) reads 0x04, so only the idle bit is set. `irq`, `scl_oe` and `sda_oe` are all low.
- R2: Register offsets are as follows.
  - 0: slave address. Only bits 5:0 are kept and read back.
  - 1: sub-address.
  - 2: payload push (write only).
  - 3: read data, which always reads 0.
  - 4: command.
  - 5: byte count minus one.
  - 7: prescaler divisor.
  - 8: FIFO fill level.
  - 9: status.
- R3: A transfer sends START, then the byte {0, addr[5:0], 0} most significant bit first, then the sub-address, then N+1 payload bytes where N is the offset 5 value, then STOP.
- R4: The payload FIFO holds 16 bytes. A push to a full FIFO is discarded. Offset 8 reports the fill level, and the FIFO is empty after every transfer.
- R5: The SCL period is 3*(div+1) system clocks, of which SCL is high for div+1 clocks.
- R6: SDA changes while SCL is high only for START (falling) and STOP (rising).
- R7: Command bit 2 (start) clears itself when the transfer begins. Status bit 2 (idle) is 0 from the start write until STOP completes. No transfer begins while command bit 1 (clock enable) is 0.
- R8: A missing acknowledge on the address byte sets status bit 1, then the controller sends STOP, empties the FIFO and returns to idle.
- R9: A missing acknowledge on the sub-address or a payload byte sets status bit 0, followed by STOP, an empty FIFO and idle.
- R10: With command bit 5 set, the end of each transfer sets status bit 3 and raises `irq`. Reading offset 9 clears both.
- R11: Writing command bit 0 (soft reset) empties the FIFO and clears the command bits and the error and interrupt bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (clears interrupt on status read) |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
A register write takes effect on the next clock, and read data is combinational, so register checks sample one clock after the write.

Bus results are not tied to a fixed cycle. A start waits up to div+1 clocks for the next tick. After that, each bit takes 3*(div+1) clocks and each byte nine bits. The engine returns to idle one tick after the STOP edge. The bench therefore waits for the STOP edge seen by its bus monitor and then lets 30 clocks pass before it reads status and FIFO level.

Bytes are compared as they complete on the bus, against a queue that the driver fills before each start. SCL period and high time are measured between edges.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_START, S_ADDR, S_SUBA, S_DATA, S_STOP
    } eng_state_t;

    localparam logic [3:0] OFS_DEV    = 4'd0;
    localparam logic [3:0] OFS_SUB    = 4'd1;
    localparam logic [3:0] OFS_PUSH   = 4'd2;
    localparam logic [3:0] OFS_CMD    = 4'd4;
    localparam logic [3:0] OFS_COUNT  = 4'd5;
    localparam logic [3:0] OFS_DIV    = 4'd7;
    localparam logic [3:0] OFS_LEVEL  = 4'd8;
    localparam logic [3:0] OFS_STATUS = 4'd9;
endpackage

// File: rtl/i2cw_tick.sv
module i2cw_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q == div) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/i2cw_fifo.sv
module i2cw_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    input  logic             flush,
    output logic [W-1:0]     dout,
    output logic [LVL_W-1:0] level
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic             do_push, do_pop;

    assign do_push = push && (level != LVL_W'(DEPTH));
    assign do_pop  = pop && (level != '0);
    assign dout    = mem[rd_q];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_q  <= '0;
            rd_q  <= '0;
            level <= '0;
        end else begin
            if (do_push) wr_q <= bump(wr_q);
            if (do_pop)  rd_q <= bump(rd_q);
            level <= level + LVL_W'(do_push) - LVL_W'(do_pop);
        end
    end
endmodule

// File: rtl/i2cw_engine.sv
module i2cw_engine
    import i2cw_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             go,
    input  logic [7:0]       dev_byte,
    input  logic [7:0]       sub_byte,
    input  logic [CNT_W-1:0] last_idx,
    input  logic [7:0]       fifo_dout,
    input  logic             sda_in,
    output logic             fifo_pop,
    output logic             taken,
    output logic             done,
    output logic             dev_nack,
    output logic             data_nack,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             cond,
    output logic             busy
);
    eng_state_t       state_q, state_d;
    logic [1:0]       phase_q, phase_d;
    logic [3:0]       bit_q, bit_d;
    logic [7:0]       shift_q, shift_d;
    logic [CNT_W-1:0] left_q, left_d;
    logic             nack_q, nack_d;
    logic             wrap;

    assign wrap = (phase_q == 2'd2);

    // next-state and handshake pulses
    always_comb begin
        state_d = state_q; phase_d = phase_q; bit_d = bit_q;
        shift_d = shift_q; left_d = left_q; nack_d = nack_q;
        taken = 1'b0; done = 1'b0; fifo_pop = 1'b0;
        dev_nack = 1'b0; data_nack = 1'b0;
        if (tick) begin
            phase_d = wrap ? 2'd0 : phase_q + 2'd1;
            unique case (state_q)
                S_IDLE: begin
                    phase_d = 2'd0;
                    if (go) begin
                        state_d = S_START;
                        taken   = 1'b1;
                    end
                end
                S_START: if (wrap) begin
                    state_d = S_ADDR;
                    bit_d   = 4'd0;
                    shift_d = dev_byte;
                end
                S_ADDR, S_SUBA, S_DATA: begin
                    if (phase_q == 2'd1 && bit_q == 4'd8) nack_d = sda_in;
                    if (wrap) begin
                        if (bit_q != 4'd8) begin
                            bit_d = bit_q + 4'd1;
                        end else begin
                            bit_d = 4'd0;
                            if (nack_q) begin
                                state_d   = S_STOP;
                                dev_nack  = (state_q == S_ADDR);
                                data_nack = (state_q != S_ADDR);
                            end else if (state_q == S_ADDR) begin
                                state_d = S_SUBA;
                                shift_d = sub_byte;
                            end else if (state_q == S_SUBA || left_q != '0) begin
                                state_d  = S_DATA;
                                shift_d  = fifo_dout;
                                fifo_pop = 1'b1;
                                left_d   = (state_q == S_SUBA) ? last_idx : left_q - 1'b1;
                            end else begin
                                state_d = S_STOP;
                            end
                        end
                    end
                end
                S_STOP: if (wrap) begin
                    state_d = S_IDLE;
                    done    = 1'b1;
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            phase_q <= 2'd0;
            bit_q   <= 4'd0;
            shift_q <= 8'd0;
            left_q  <= '0;
            nack_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            bit_q   <= bit_d;
            shift_q <= shift_d;
            left_q  <= left_d;
            nack_q  <= nack_d;
        end
    end

    // bus outputs
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        cond   = 1'b0;
        busy   = (state_q != S_IDLE);
        unique case (state_q)
            S_IDLE: ;
            S_START: begin
                cond   = 1'b1;
                sda_oe = (phase_q != 2'd0);
                scl_oe = (phase_q == 2'd2);
            end
            S_STOP: begin
                cond   = 1'b1;
                sda_oe = (phase_q != 2'd2);
                scl_oe = (phase_q == 2'd0);
            end
            S_ADDR, S_SUBA, S_DATA: begin
                scl_oe = (phase_q != 2'd1);
                sda_oe = (bit_q == 4'd8) ? 1'b0 : ~shift_q[3'd7 - bit_q[2:0]];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/i2cw_master.sv
module i2cw_master
    import i2cw_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int DIV_W      = 8,
    localparam int CNT_W     = $clog2(FIFO_DEPTH),
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] reg_addr,
    input  logic [7:0] reg_wdata,
    input  logic       reg_we,
    input  logic       reg_re,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       sda_in
);
    logic             soft_q, srst_n;
    logic [5:0]       dev_q;
    logic [7:0]       sub_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_q;
    logic             clk_en_q, start_q, rd_sel_q, comb_q, irq_en_q;
    logic             dev_err_q, data_err_q;
    logic             tick, taken, done, dev_nack, data_nack, eng_cond, busy;
    logic             fifo_pop, push;
    logic [7:0]       fifo_dout;
    logic [LVL_W-1:0] fifo_level;
    logic             idle_bit, cmd_wr;

    assign srst_n   = rst_n & ~soft_q;
    assign cmd_wr   = reg_we && reg_addr == OFS_CMD;
    assign push     = reg_we && reg_addr == OFS_PUSH;
    assign idle_bit = !busy && !start_q;

    always_ff @(posedge clk) begin
        if (!rst_n) soft_q <= 1'b0;
        else        soft_q <= cmd_wr && reg_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (!srst_n) begin
            dev_q <= '0; sub_q <= '0; cnt_q <= '0; div_q <= '0;
            clk_en_q <= 1'b0; start_q <= 1'b0; rd_sel_q <= 1'b0;
            comb_q <= 1'b0; irq_en_q <= 1'b0;
            dev_err_q <= 1'b0; data_err_q <= 1'b0; irq <= 1'b0;
        end else begin
            if (reg_we) begin
                unique case (reg_addr)
                    OFS_DEV:   dev_q <= reg_wdata[5:0];
                    OFS_SUB:   sub_q <= reg_wdata;
                    OFS_COUNT: cnt_q <= reg_wdata[CNT_W-1:0];
                    OFS_DIV:   div_q <= reg_wdata[DIV_W-1:0];
                    OFS_CMD: begin
                        clk_en_q <= reg_wdata[1];
                        start_q  <= reg_wdata[2];
                        rd_sel_q <= reg_wdata[3];
                        comb_q   <= reg_wdata[4];
                        irq_en_q <= reg_wdata[5];
                    end
                    default: ;
                endcase
            end
            if (taken) begin
                start_q    <= 1'b0;
                dev_err_q  <= 1'b0;
                data_err_q <= 1'b0;
            end
            if (dev_nack)  dev_err_q  <= 1'b1;
            if (data_nack) data_err_q <= 1'b1;
            if (reg_re && reg_addr == OFS_STATUS) irq <= 1'b0;
            if (done && irq_en_q) irq <= 1'b1;
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_DEV:    reg_rdata = {2'b00, dev_q};
            OFS_SUB:    reg_rdata = sub_q;
            OFS_CMD:    reg_rdata = {2'b00, irq_en_q, comb_q, rd_sel_q, start_q, clk_en_q, 1'b0};
            OFS_COUNT:  reg_rdata = 8'(cnt_q);
            OFS_DIV:    reg_rdata = 8'(div_q);
            OFS_LEVEL:  reg_rdata = 8'(fifo_level);
            OFS_STATUS: reg_rdata = {4'b0000, irq, idle_bit, dev_err_q, data_err_q};
            default:    reg_rdata = 8'h00;
        endcase
    end

    i2cw_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(srst_n), .en(clk_en_q), .div(div_q), .tick(tick)
    );

    i2cw_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst_n(srst_n), .push(push), .din(reg_wdata),
        .pop(fifo_pop), .flush(done), .dout(fifo_dout), .level(fifo_level)
    );

    i2cw_engine #(.CNT_W(CNT_W)) u_eng (
        .clk(clk), .rst_n(srst_n), .tick(tick), .go(start_q),
        .dev_byte({1'b0, dev_q, 1'b0}), .sub_byte(sub_q), .last_idx(cnt_q),
        .fifo_dout(fifo_dout), .sda_in(sda_in), .fifo_pop(fifo_pop),
        .taken(taken), .done(done), .dev_nack(dev_nack), .data_nack(data_nack),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .cond(eng_cond), .busy(busy)
    );
endmodule

// File: rtl/i2cw_checks.sv
module i2cw_checks #(
    parameter int LVL_W = 5,
    parameter int DEPTH = 16
) (
    input logic             clk,
    input logic             srst_n,
    input logic             scl_oe,
    input logic             sda_oe,
    input logic             eng_cond,
    input logic [LVL_W-1:0] fifo_level,
    input logic             idle_bit,
    input logic             taken,
    input logic             start_q,
    input logic             irq,
    input logic             irq_en_q,
    input logic             dev_err_q,
    input logic             data_err_q
);
    // R6: SDA moves under high SCL only inside START/STOP
    p_sda_hold_r6: assert property (@(posedge clk) disable iff (!srst_n)
        (!scl_oe && !$past(scl_oe) && sda_oe != $past(sda_oe)) |-> eng_cond);

    // R4: level never exceeds capacity
    p_level_cap_r4: assert property (@(posedge clk) disable iff (!srst_n)
        fifo_level <= LVL_W'(DEPTH));

    // R7: idle status means a released bus
    p_idle_bus_r7: assert property (@(posedge clk) disable iff (!srst_n)
        idle_bit |-> (!scl_oe && !sda_oe));

    // R7: start bit drops once the engine accepts it
    p_start_clear_r7: assert property (@(posedge clk) disable iff (!srst_n)
        taken |=> !start_q);

    // R10: interrupt only rises when enabled
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!srst_n)
        $rose(irq) |-> irq_en_q);

    // R8 / R9: one error class per transfer
    p_err_excl_r8: assert property (@(posedge clk) disable iff (!srst_n)
        !(dev_err_q && data_err_q));
endmodule

bind i2cw_master i2cw_checks #(.LVL_W(LVL_W), .DEPTH(FIFO_DEPTH)) u_checks (
    .clk(clk), .srst_n(srst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .eng_cond(eng_cond), .fifo_level(fifo_level), .idle_bit(idle_bit),
    .taken(taken), .start_q(start_q), .irq(irq), .irq_en_q(irq_en_q),
    .dev_err_q(dev_err_q), .data_err_q(data_err_q)
);

// File: tb/i2cw_master_bench.sv
`timescale 1ns/1ps
module i2cw_master_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_we = 1'b0, reg_re = 1'b0;
    logic [7:0] reg_rdata;
    logic       irq, scl_oe, sda_oe;
    logic       slave_pull = 1'b0;
    logic       scl, sda;

    assign scl = ~scl_oe;
    assign sda = ~(sda_oe | slave_pull);

    i2cw_master u_i2cw_master (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata), .irq(irq),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda)
    );

    always #4 clk = ~clk;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // scoreboard state
    logic [7:0] exp_q[$];
    int  nack_at = -1, byte_idx = 0, bitcnt = 0;
    int  starts = 0, stops = 0, cyc = 0, last_rise = -1;
    int  per_min, per_max, hi_min, hi_max;
    logic [7:0] sh = '0;
    logic scl_p = 1'b1, sda_p = 1'b1;

    // driver: queue the bytes the bus must carry
    task automatic expect_frame(input logic [5:0] dev, input logic [7:0] sub,
                                input logic [7:0] data[$], input int nack);
        exp_q.delete();
        exp_q.push_back({1'b0, dev, 1'b0});
        if (nack != 0) exp_q.push_back(sub);
        for (int i = 0; i < data.size(); i++)
            if (nack < 0 || i + 2 <= nack) exp_q.push_back(data[i]);
        nack_at = nack; byte_idx = 0;
        per_min = 1 << 30; per_max = 0; hi_min = 1 << 30; hi_max = 0;
    endtask

    // monitor: decode the bus and compare against the queue
    always @(negedge clk) begin
        cyc++;
        if (scl_p && scl && sda_p && !sda) begin
            starts++; bitcnt = 0; last_rise = -1;
        end else if (scl_p && scl && !sda_p && sda) begin
            stops++;
        end else if (!scl_p && scl) begin
            if (last_rise >= 0) begin
                if (cyc - last_rise < per_min) per_min = cyc - last_rise;
                if (cyc - last_rise > per_max) per_max = cyc - last_rise;
            end
            last_rise = cyc;
            if (bitcnt < 8) begin
                sh = {sh[6:0], sda};
                bitcnt++;
                if (bitcnt == 8) begin
                    if (exp_q.size() == 0) check(1'b0, "R3 unexpected byte", sh, 0);
                    else begin
                        automatic logic [7:0] e = exp_q.pop_front();
                        check(sh == e, "R3 bus byte", sh, e);
                    end
                end
            end else bitcnt = 9;
        end else if (scl_p && !scl) begin
            if (last_rise >= 0) begin
                if (cyc - last_rise < hi_min) hi_min = cyc - last_rise;
                if (cyc - last_rise > hi_max) hi_max = cyc - last_rise;
            end
            if (bitcnt == 8) slave_pull = (byte_idx != nack_at);
            else if (bitcnt == 9) begin
                slave_pull = 1'b0; bitcnt = 0; byte_idx++;
            end
        end
        scl_p = scl; sda_p = sda;
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_re = 1'b1; #1 d = reg_rdata;
        @(negedge clk); reg_re = 1'b0;
    endtask

    task automatic wait_frame(input int stops_before, input string tag);
        int n = 0;
        while (stops == stops_before && n < 20000) begin @(negedge clk); n++; end
        check(stops > stops_before, tag, stops, stops_before + 1);
        repeat (30) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
        summary();
    end

    initial begin
        logic [7:0] v;
        logic [7:0] pay[$];
        int s0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(4'd9, v); check(v == 8'h04, "R1 status", v, 8'h04);
        check(!irq && !scl_oe && !sda_oe, "R1 outputs", {irq, scl_oe, sda_oe}, 0);

        // R2: register map
        wr(4'd7, 8'd2); wr(4'd4, 8'h02);
        wr(4'd0, 8'hEA); rd(4'd0, v); check(v == 8'h2A, "R2 addr low bits", v, 8'h2A);
        wr(4'd1, 8'h5C); rd(4'd1, v); check(v == 8'h5C, "R2 subaddr", v, 8'h5C);
        rd(4'd3, v); check(v == 8'h00, "R2 read-data stub", v, 0);
        wr(4'd5, 8'd2);
        pay = '{8'hA1, 8'hB2, 8'hC3};
        foreach (pay[i]) wr(4'd2, pay[i]);
        rd(4'd8, v); check(v == 8'd3, "R4 level", v, 3);

        // R3: three-byte frame, div 2
        expect_frame(6'h2A, 8'h5C, pay, -1);
        s0 = stops; starts = 0;
        wr(4'd4, 8'h06);
        rd(4'd9, v); check(v[2] == 1'b0, "R7 idle low after start", v, 0);
        repeat (10) @(negedge clk);
        rd(4'd4, v); check(v[2] == 1'b0, "R7 start self-clear", v, 8'h02);
        wait_frame(s0, "R3 stop seen");
        check(exp_q.size() == 0, "R3 all bytes sent", exp_q.size(), 0);
        check(starts == 1, "R6 single START", starts, 1);
        rd(4'd9, v); check(v == 8'h04, "R3 status clean", v, 8'h04);
        rd(4'd8, v); check(v == 8'd0, "R4 empty after", v, 0);
        check(per_min == 9 && per_max == 9, "R5 period div2", per_max, 9);
        check(hi_min == 3 && hi_max == 3, "R5 high div2", hi_max, 3);

        // R5: single byte, div 5
        wr(4'd7, 8'd5); wr(4'd1, 8'h11); wr(4'd5, 8'd0); wr(4'd2, 8'h3C);
        pay = '{8'h3C};
        expect_frame(6'h2A, 8'h11, pay, -1);
        s0 = stops;
        wr(4'd4, 8'h06);
        wait_frame(s0, "R3 stop seen 1B");
        check(exp_q.size() == 0, "R3 one byte", exp_q.size(), 0);
        check(per_min == 18 && per_max == 18, "R5 period div5", per_max, 18);
        check(hi_min == 6 && hi_max == 6, "R5 high div5", hi_max, 6);

        // R4: full FIFO, 17th push dropped
        wr(4'd7, 8'd2); wr(4'd5, 8'd15);
        pay.delete();
        for (int i = 0; i < 16; i++) begin
            pay.push_back(8'(i * 7 + 1));
            wr(4'd2, 8'(i * 7 + 1));
        end
        wr(4'd2, 8'hFF);
        rd(4'd8, v); check(v == 8'd16, "R4 full level", v, 16);
        expect_frame(6'h2A, 8'h11, pay, -1);
        s0 = stops;
        wr(4'd4, 8'h06);
        wait_frame(s0, "R4 stop seen");
        check(exp_q.size() == 0, "R4 sixteen bytes", exp_q.size(), 0);

        // R8 + R10: address NACK with interrupt
        wr(4'd5, 8'd1); wr(4'd2, 8'h55); wr(4'd2, 8'h66);
        pay = '{8'h55, 8'h66};
        expect_frame(6'h2A, 8'h11, pay, 0);
        s0 = stops;
        wr(4'd4, 8'h26);
        wait_frame(s0, "R8 stop seen");
        check(exp_q.size() == 0, "R8 only address sent", exp_q.size(), 0);
        check(irq == 1'b1, "R10 irq raised", irq, 1);
        rd(4'd8, v); check(v == 8'd0, "R8 fifo flushed", v, 0);
        rd(4'd9, v); check(v == 8'h0E, "R8 dev error", v, 8'h0E);
        check(irq == 1'b0, "R10 irq cleared by read", irq, 0);
        rd(4'd9, v); check(v == 8'h06, "R10 status bit cleared", v, 8'h06);

        // R9: NACK on second payload byte
        wr(4'd5, 8'd3);
        pay = '{8'h10, 8'h20, 8'h30, 8'h40};
        foreach (pay[i]) wr(4'd2, pay[i]);
        expect_frame(6'h2A, 8'h11, pay, 3);
        s0 = stops;
        wr(4'd4, 8'h26);
        wait_frame(s0, "R9 stop seen");
        check(exp_q.size() == 0, "R9 bytes until nack", exp_q.size(), 0);
        rd(4'd8, v); check(v == 8'd0, "R9 fifo flushed", v, 0);
        rd(4'd9, v); check(v == 8'h0D, "R9 data error", v, 8'h0D);

        // R7: no transfer without clock enable
        wr(4'd4, 8'h00); wr(4'd5, 8'd0); wr(4'd2, 8'h77);
        exp_q.delete();
        s0 = starts;
        wr(4'd4, 8'h04);
        repeat (60) @(negedge clk);
        check(starts == s0, "R7 held without clock", starts, s0);
        rd(4'd9, v); check(v == 8'h01, "R7 pending not idle", v, 8'h01);
        rd(4'd4, v); check(v == 8'h04, "R7 start pending", v, 8'h04);

        // R11: soft reset
        wr(4'd4, 8'h01);
        @(negedge clk);
        rd(4'd8, v); check(v == 8'd0, "R11 fifo cleared", v, 0);
        rd(4'd4, v); check(v == 8'h00, "R11 cmd cleared", v, 0);
        rd(4'd9, v); check(v == 8'h04, "R11 status cleared", v, 8'h04);
        check(starts == s0, "R11 no transfer", starts, s0);

        summary();
    end
endmodule